// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device end of an ATA task-file register set. A host reaches it through a byte-wide register bus with eight offsets. Offset 0 is a 16-bit data port. The block stores the parameter registers and keeps the status byte. It runs three command families: IDENTIFY, FLUSH CACHE, and READ/WRITE DMA setup. It drives one interrupt line.

IDENTIFY moves 256 words of PIO data-in. The words are produced by a small computed ROM that carries a serial string, a version string and a write-cache flag. FLUSH CACHE holds the device busy and raises a request line until an external completion strobe arrives. READ DMA and WRITE DMA present the 24-bit LBA and the sector count to a DMA engine with a one-cycle start pulse, and stay busy until that engine strobes done. The status bits follow the busy / ready / data-request sequence of each command. The interrupt drops when the host reads status.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, status reads 0x40 (bit 6 ready set, all else clear), and irq, flush_req and dma_start are all low.
- R2: Bytes written to offsets 1 to 6 read back on rd_data[7:0] with rd_data[15:8] zero. Offset 6 is the device register: bit 4 is the device select and bit 6 is the LBA-mode flag.
- R3: Writing 0xEC to offset 7 starts IDENTIFY. Status then reads 0x48 (ready and data request set; busy, fault and error clear) before every one of the 256 data-port reads, and irq rises when the data becomes available.
- R4: After the 256th data-port read, the data-request bit clears and status reads 0x40, with no new interrupt.
- R5: IDENTIFY word 10+k (k = 0..9) holds serial characters 2k (high byte) and 2k+1 (low byte). Word 23+k (k = 0..3) holds the version characters in the same order. Word 85 bit 5 is set when the write cache is enabled. Every other word reads 0.
- R6: A read of offset 7 deasserts irq on the next clock, unless a new interrupt event occurs in that same cycle.
- R7: Writing 0xE7 (FLUSH CACHE) sets status to 0xC0 (busy and ready) and holds flush_req high until a flush_done strobe. One cycle after the strobe, status reads 0x40 and irq is high.
- R8: Writing 0xC8 (READ DMA, dma_to_host=1) or 0xCA (WRITE DMA, dma_to_host=0) pulses dma_start for exactly one cycle. It presents dma_lba = {offset 5, offset 4, offset 3} and dma_count = offset 2, and keeps status at 0xC0 until dma_done. After dma_done, status reads 0x40 and irq is high.
- R9: Any other command code sets status to 0x41 (ready and error) and raises irq. The next accepted command clears the error bit.
- R10: A command write while the device-select bit is 1 is ignored: status, irq, flush_req and dma_start do not change.
- R11: A command write while busy or data-request is set is ignored.
- R12: Writes to offsets 1 to 6 while busy is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data (low byte for offsets 1 to 7) |
| rd_en | input | 1 | Register read strobe (side effects on offsets 0 and 7) |
| rd_data | output | 16 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request to the host |
| flush_req | output | 1 | Cache flush in progress |
| flush_done | input | 1 | Flush completion strobe |
| dma_start | output | 1 | One-cycle DMA launch pulse |
| dma_to_host | output | 1 | DMA direction, 1 = device to host |
| dma_lba | output | 24 | Starting LBA for the DMA engine |
| dma_count | output | 8 | Sector count for the DMA engine |
| dma_done | input | 1 | DMA completion strobe |

## Verification
A wrong word index in the PIO sequencer shows up at once as a misplaced serial or version word on the data port. It also shows up as a data-request bit that drops one read too early or too late. A stuck busy or interrupt flag is seen on the very next status read, or on the irq pin one clock after a completion strobe. A lost or doubled DMA launch is visible on dma_start in the cycle after the command write. The LBA byte order is checked against values built from three distinct bytes.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_LBA0  = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_LBA1  = 3'd4;
   localparam logic [ADDR_W-1:0] OFS_LBA2  = 3'd5;
   localparam logic [ADDR_W-1:0] OFS_DEV   = 3'd6;
   localparam logic [ADDR_W-1:0] OFS_CMD   = 3'd7;

   localparam logic [7:0] OP_IDENT = 8'hEC;
   localparam logic [7:0] OP_FLUSH = 8'hE7;
   localparam logic [7:0] OP_DMA_R = 8'hC8;
   localparam logic [7:0] OP_DMA_W = 8'hCA;

   localparam int DEV_SEL_BIT = 4;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_PIO_IN,
      SQ_FLUSH,
      SQ_DMA
   } seq_state_t;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs #(
   parameter int REG_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ata_tf_pkg::ADDR_W-1:0]  addr,
   input  logic                           wr_en,
   input  logic [REG_W-1:0]               wr_byte,
   input  logic                           busy,
   output logic [6:1][REG_W-1:0]          file_q
);
   logic in_range;
   assign in_range = (addr != ata_tf_pkg::OFS_DATA) && (addr != ata_tf_pkg::OFS_CMD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         file_q <= '0;
      end else if (wr_en && in_range && !busy) begin
         for (int k = 1; k <= 6; k++) begin
            if (addr == ata_tf_pkg::ADDR_W'(k)) file_q[k] <= wr_byte;
         end
      end
   end
endmodule

// File: rtl/ata_tf_ident_rom.sv
module ata_tf_ident_rom #(
   parameter int   WORD_W    = 16,
   parameter int   ID_WORDS  = 256,
   parameter int   SER_WORDS = 10,
   parameter int   VER_WORDS = 4,
   parameter logic [16*SER_WORDS-1:0] SERIAL  = '0,
   parameter logic [16*VER_WORDS-1:0] VERSION = '0,
   parameter bit   WCACHE_ON = 1'b1,
   localparam int  IDX_W = $clog2(ID_WORDS)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] word
);
   localparam int SER_BASE = 10;
   localparam int VER_BASE = 23;
   localparam int CAP_WORD = 85;

   logic [WORD_W-1:0] cap_val;

   generate
      if (WCACHE_ON) begin : g_wc_on
         assign cap_val = WORD_W'(16'h0020);
      end else begin : g_wc_off
         assign cap_val = '0;
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int k = 0; k < SER_WORDS; k++) begin
         if (idx == IDX_W'(SER_BASE + k)) word = WORD_W'(SERIAL[16*(SER_WORDS-k)-1 -: 16]);
      end
      for (int k = 0; k < VER_WORDS; k++) begin
         if (idx == IDX_W'(VER_BASE + k)) word = WORD_W'(VERSION[16*(VER_WORDS-k)-1 -: 16]);
      end
      if (idx == IDX_W'(CAP_WORD)) word = cap_val;
   end
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq #(
   parameter int  ID_WORDS = 256,
   localparam int IDX_W    = $clog2(ID_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [7:0]       cmd_code,
   input  logic             dev_sel,
   input  logic             data_rd,
   input  logic             stat_rd,
   input  logic             flush_done,
   input  logic             dma_done,
   output logic             bsy,
   output logic             drq,
   output logic             err,
   output logic             irq,
   output logic [IDX_W-1:0] word_idx,
   output logic             dma_start,
   output logic             dma_to_host,
   output logic             flush_req
);
   import ata_tf_pkg::*;

   seq_state_t state_q;
   logic accept, is_ident, is_flush, is_dma, unknown, irq_set, last_word;

   assign accept    = cmd_wr && !dev_sel && (state_q == SQ_IDLE);
   assign is_ident  = (cmd_code == OP_IDENT);
   assign is_flush  = (cmd_code == OP_FLUSH);
   assign is_dma    = (cmd_code == OP_DMA_R) || (cmd_code == OP_DMA_W);
   assign unknown   = !(is_ident || is_flush || is_dma);
   assign last_word = (word_idx == IDX_W'(ID_WORDS - 1));
   assign irq_set   = (accept && (is_ident || unknown))
                   || (state_q == SQ_FLUSH && flush_done)
                   || (state_q == SQ_DMA   && dma_done);

   assign bsy       = (state_q == SQ_FLUSH) || (state_q == SQ_DMA);
   assign drq       = (state_q == SQ_PIO_IN);
   assign flush_req = (state_q == SQ_FLUSH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         err         <= 1'b0;
         irq         <= 1'b0;
         word_idx    <= '0;
         dma_start   <= 1'b0;
         dma_to_host <= 1'b0;
      end else begin
         dma_start <= 1'b0;
         if (irq_set)      irq <= 1'b1;
         else if (stat_rd) irq <= 1'b0;

         case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  err <= unknown;
                  if (is_ident) begin
                     state_q  <= SQ_PIO_IN;
                     word_idx <= '0;
                  end else if (is_flush) begin
                     state_q <= SQ_FLUSH;
                  end else if (is_dma) begin
                     state_q     <= SQ_DMA;
                     dma_start   <= 1'b1;
                     dma_to_host <= (cmd_code == OP_DMA_R);
                  end
               end
            end
            SQ_PIO_IN: begin
               if (data_rd) begin
                  if (last_word) begin
                     state_q  <= SQ_IDLE;
                     word_idx <= '0;
                  end else begin
                     word_idx <= word_idx + 1'b1;
                  end
               end
            end
            SQ_FLUSH: if (flush_done) state_q <= SQ_IDLE;
            SQ_DMA:   if (dma_done)   state_q <= SQ_IDLE;
            default:  state_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl #(
   parameter int  REG_W     = 8,
   parameter int  DATA_W    = 16,
   parameter int  ID_WORDS  = 256,
   parameter int  SER_WORDS = 10,
   parameter int  VER_WORDS = 4,
   parameter logic [16*SER_WORDS-1:0] SERIAL  = "TFC-DEVICE-00000017 ",
   parameter logic [16*VER_WORDS-1:0] VERSION = "REV 2.1 ",
   parameter bit  WCACHE_ON = 1'b1,
   localparam int LBA_W     = 3 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              flush_req,
   input  logic              flush_done,
   output logic              dma_start,
   output logic              dma_to_host,
   output logic [LBA_W-1:0]  dma_lba,
   output logic [REG_W-1:0]  dma_count,
   input  logic              dma_done
);
   import ata_tf_pkg::*;
   localparam int IDX_W = $clog2(ID_WORDS);

   generate
      if (REG_W != 8) begin : g_bad_reg_w
         $error("REG_W must be 8");
      end
      if (DATA_W != 2 * REG_W) begin : g_bad_data_w
         $error("DATA_W must be twice REG_W");
      end
      if (ID_WORDS < 86 || ID_WORDS > 4096) begin : g_bad_words
         $error("ID_WORDS must cover word 85 and stay small");
      end
   endgenerate

   logic [6:1][REG_W-1:0] file_q;
   logic bsy, drq, err, dev_sel;
   logic [IDX_W-1:0]  word_idx;
   logic [DATA_W-1:0] id_word;
   logic [7:0]        stat_byte;

   assign dev_sel   = file_q[6][DEV_SEL_BIT];
   assign stat_byte = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};

   ata_tf_regs #(.REG_W(REG_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(wr_en),
      .wr_byte(wr_data[REG_W-1:0]), .busy(bsy), .file_q(file_q)
   );

   ata_tf_ident_rom #(
      .WORD_W(DATA_W), .ID_WORDS(ID_WORDS), .SER_WORDS(SER_WORDS),
      .VER_WORDS(VER_WORDS), .SERIAL(SERIAL), .VERSION(VERSION),
      .WCACHE_ON(WCACHE_ON)
   ) i_rom (
      .idx(word_idx), .word(id_word)
   );

   ata_tf_seq #(.ID_WORDS(ID_WORDS)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr(wr_en && reg_addr == OFS_CMD),
      .cmd_code(wr_data[7:0]), .dev_sel(dev_sel),
      .data_rd(rd_en && reg_addr == OFS_DATA),
      .stat_rd(rd_en && reg_addr == OFS_CMD),
      .flush_done(flush_done), .dma_done(dma_done),
      .bsy(bsy), .drq(drq), .err(err), .irq(irq), .word_idx(word_idx),
      .dma_start(dma_start), .dma_to_host(dma_to_host), .flush_req(flush_req)
   );

   assign dma_lba   = {file_q[OFS_LBA2], file_q[OFS_LBA1], file_q[OFS_LBA0]};
   assign dma_count = file_q[OFS_COUNT];

   always_comb begin
      rd_data = '0;
      case (reg_addr)
         OFS_DATA: rd_data = drq ? id_word : '0;
         OFS_CMD:  rd_data = DATA_W'(stat_byte);
         default:  rd_data = DATA_W'(file_q[reg_addr]);
      endcase
   end
endmodule

// File: rtl/ata_taskfile_ctrl_chk.sv
module ata_taskfile_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] reg_addr,
   input logic       wr_en,
   input logic       rd_en,
   input logic       flush_done,
   input logic       dma_done,
   input logic       dev_sel,
   input logic [7:0] stat_byte,
   input logic       irq,
   input logic       flush_req,
   input logic       dma_start
);
   logic cmd_wr, stat_rd;
   assign cmd_wr  = wr_en && reg_addr == 3'd7;
   assign stat_rd = rd_en && reg_addr == 3'd7;

   p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n) stat_byte[6]);
   p_no_bsy_drq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_byte[7] && stat_byte[3]));
   p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !cmd_wr && !flush_done && !dma_done) |=> !irq);
   p_flush_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> stat_byte[7]);
   p_dma_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |=> !dma_start);
   p_dma_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |-> stat_byte[7]);
   p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[0] |-> !stat_byte[7] && !stat_byte[3]);
   p_dev1_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && dev_sel && !stat_byte[7] && !stat_byte[3]) |=> $stable(stat_byte));
   p_busy_cmd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_byte[7] && cmd_wr && !flush_done && !dma_done) |=> stat_byte[7]);
endmodule

bind ata_taskfile_ctrl ata_taskfile_ctrl_chk i_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
   .flush_done(flush_done), .dma_done(dma_done), .dev_sel(dev_sel),
   .stat_byte(stat_byte), .irq(irq), .flush_req(flush_req), .dma_start(dma_start)
);

// File: tb/test_ata_taskfile_ctrl.sv
module test_ata_taskfile_ctrl;
   localparam string SER_S = "BENCH-SERIAL-XY9876";
   localparam string VER_S = "FW-7.03b";

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        irq, flush_req, dma_start, dma_to_host;
   logic        flush_done = 1'b0, dma_done = 1'b0;
   logic [23:0] dma_lba;
   logic [7:0]  dma_count;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ata_taskfile_ctrl #(
      .SERIAL({"BENCH-SERIAL-XY9876", " "}),
      .VERSION("FW-7.03b")
   ) i_ata_taskfile_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
      .flush_req(flush_req), .flush_done(flush_done), .dma_start(dma_start),
      .dma_to_host(dma_to_host), .dma_lba(dma_lba), .dma_count(dma_count),
      .dma_done(dma_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic strobe_flush();
      @(negedge clk); flush_done = 1'b1;
      @(negedge clk); flush_done = 1'b0;
   endtask

   task automatic strobe_dma();
      @(negedge clk); dma_done = 1'b1;
      @(negedge clk); dma_done = 1'b0;
   endtask

   function automatic logic [15:0] exp_word(input int i);
      string ser;
      ser = {SER_S, " "};
      if (i >= 10 && i < 20) return {ser.getc(2*(i-10)), ser.getc(2*(i-10)+1)};
      if (i >= 23 && i < 27) return {VER_S.getc(2*(i-23)), VER_S.getc(2*(i-23)+1)};
      if (i == 85) return 16'h0020;
      return 16'h0000;
   endfunction

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 irq", 32'(irq), 0);
      chk("R1 flush_req", 32'(flush_req), 0);
      chk("R1 dma_start", 32'(dma_start), 0);
      bus_rd(3'd7, d);
      chk("R1 status", 32'(d), 32'h40);
   endtask

   task automatic t_regs();
      logic [15:0] d;
      for (int k = 1; k <= 6; k++) bus_wr(3'(k), 16'hA500 | 16'(8'h11 * k));
      for (int k = 1; k <= 6; k++) begin
         bus_rd(3'(k), d);
         chk("R2 readback", 32'(d), 32'(8'h11 * k));
      end
      bus_wr(3'd6, 16'h0040);
   endtask

   task automatic t_identify();
      logic [15:0] d;
      int bad_stat = 0, bad_word = 0;
      bus_wr(3'd7, 16'h00EC);
      chk("R3 irq on data ready", 32'(irq), 1);
      bus_rd(3'd7, d);
      chk("R3 status after cmd", 32'(d), 32'h48);
      chk("R6 irq cleared by status read", 32'(irq), 0);
      for (int i = 0; i < 256; i++) begin
         bus_rd(3'd7, d);
         if (d !== 16'h48) begin
            bad_stat++;
            $display("FAIL R3 word %0d status actual=%h expected=%h", i, d, 16'h48);
         end
         bus_rd(3'd0, d);
         if (d !== exp_word(i)) begin
            bad_word++;
            $display("FAIL R5 word %0d actual=%h expected=%h", i, d, exp_word(i));
         end
      end
      checks += 2; errors += (bad_stat != 0) + (bad_word != 0);
      chk("R4 no irq at end", 32'(irq), 0);
      bus_rd(3'd7, d);
      chk("R4 status after last word", 32'(d), 32'h40);
   endtask

   task automatic t_flush_and_busy();
      logic [15:0] d;
      bus_wr(3'd2, 16'h0003);
      bus_wr(3'd7, 16'h00E7);
      chk("R7 flush_req", 32'(flush_req), 1);
      bus_rd(3'd7, d);
      chk("R7 status pending", 32'(d), 32'hC0);
      bus_wr(3'd2, 16'h0077);
      bus_wr(3'd7, 16'h00EC);
      bus_rd(3'd7, d);
      chk("R11 command ignored while busy", 32'(d), 32'hC0);
      chk("R11 no irq", 32'(irq), 0);
      strobe_flush();
      chk("R7 flush_req dropped", 32'(flush_req), 0);
      chk("R7 irq on completion", 32'(irq), 1);
      bus_rd(3'd7, d);
      chk("R7 status done", 32'(d), 32'h40);
      chk("R6 irq cleared", 32'(irq), 0);
      bus_rd(3'd2, d);
      chk("R12 write while busy ignored", 32'(d), 32'h03);
   endtask

   task automatic t_dma(input logic [7:0] op, input logic to_host);
      logic [15:0] d;
      bus_wr(3'd2, 16'h0005);
      bus_wr(3'd3, 16'h0034);
      bus_wr(3'd4, 16'h0012);
      bus_wr(3'd5, 16'h00AB);
      bus_wr(3'd7, {8'h00, op});
      chk("R8 dma_start pulse", 32'(dma_start), 1);
      chk("R8 direction", 32'(dma_to_host), 32'(to_host));
      chk("R8 lba", 32'(dma_lba), 32'hAB1234);
      chk("R8 count", 32'(dma_count), 32'h05);
      @(negedge clk);
      chk("R8 dma_start one cycle", 32'(dma_start), 0);
      bus_rd(3'd7, d);
      chk("R8 status busy", 32'(d), 32'hC0);
      strobe_dma();
      chk("R8 irq on done", 32'(irq), 1);
      bus_rd(3'd7, d);
      chk("R8 status done", 32'(d), 32'h40);
   endtask

   task automatic t_unknown();
      logic [15:0] d;
      bus_wr(3'd7, 16'h0055);
      chk("R9 irq", 32'(irq), 1);
      bus_rd(3'd7, d);
      chk("R9 status error", 32'(d), 32'h41);
      bus_wr(3'd7, 16'h00E7);
      bus_rd(3'd7, d);
      chk("R9 error cleared by next command", 32'(d), 32'hC0);
      strobe_flush();
      bus_rd(3'd7, d);
   endtask

   task automatic t_dev1();
      logic [15:0] d;
      bus_wr(3'd6, 16'h0050);
      bus_wr(3'd7, 16'h00E7);
      chk("R10 flush_req", 32'(flush_req), 0);
      chk("R10 irq", 32'(irq), 0);
      bus_wr(3'd7, 16'h00C8);
      chk("R10 dma_start", 32'(dma_start), 0);
      bus_rd(3'd7, d);
      chk("R10 status", 32'(d), 32'h40);
      bus_wr(3'd6, 16'h0040);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_identify();
      t_flush_and_busy();
      t_dma(8'hC8, 1'b1);
      t_dma(8'hCA, 1'b0);
      t_unknown();
      t_dev1();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule